// File: doc/BRIEF.md
# Mailbox Transmit Controller

This block is the sending half of an inter-core mailbox. Software stages a 64-bit message as two 32-bit words, chooses one of eight destination cores, and then writes a launch command. The message is then presented to that destination on its own outbound stream. It stays there until the remote core takes it. For each destination the block tracks three flags: a message is still pending, the message has been taken, and a launch arrived while a message was still pending. All three are packed into one status word.

The destination streams follow valid/ready rules. `tgt_valid[i]` rises on the cycle after a launch to an idle destination. It stays high with `tgt_data` slice `i` held stable until a cycle where `tgt_ready[i]` is also high. That cycle is the fetch. The block never withdraws a message, and a remote core may hold `tgt_ready` low for as long as it likes. A single interrupt line reports delivery and overflow events, subject to a three-bit mask. Software acknowledges the interrupt with a write-one-to-clear register. A second write-one-to-clear register clears the delivered and overflow flags one bit at a time.

The register port is a plain single-cycle write strobe plus a combinational read of the addressed word. Word addresses are 0x00 destination, 0x04 low word, 0x08 high word, 0x0C launch, 0x10 flag clear, 0x14 status, 0x18 interrupt pending and 0x1C interrupt mask. Any other address reads zero and ignores writes. The status packing supports up to eight destinations.

Top module: `mbx_tx_ctrl`

## Requirements
- R1: After reset, the mask register (0x1C) reads 7, the status (0x14) and pending (0x18) registers read 0, `irq` is low, and all `tgt_valid` bits are low.
- R2: The destination register (0x00) keeps only bits [2:0] of a write. The low (0x04) and high (0x08) word registers read back exactly what was written.
- R3: Writing 0x0C with bit 0 set to an idle destination raises that `tgt_valid` bit on the next cycle. The message appears with the high word in bits [63:32] and the low word in [31:0]. Status bit [i] (busy) reads 1, and the data stays stable while the message is not taken.
- R4: A cycle with `tgt_valid[i]` and `tgt_ready[i]` both high clears busy bit [i] and the valid bit on the next cycle, and sets delivered bit [16+i].
- R5: A launch aimed at a destination that is still busy leaves its pending message unchanged and sets overflow bit [8+i].
- R6: A write to 0x10 clears exactly the delivered bits [23:16] and overflow bits [15:8] that are 1 in the written value. Busy bits are not affected.
- R7: A delivery sets the pending bit (0x18 bit 0) only when mask bit 0 (global) and mask bit 2 (delivery) are both 0. `irq` is high exactly while the pending bit is set.
- R8: An overflow sets the pending bit only when mask bit 0 and mask bit 1 (overflow) are both 0.
- R9: Writing 1 to bit 0 of 0x18 clears the pending bit and drops `irq` on the next cycle, provided no new event occurs in that cycle.
- R10: A write to 0x0C with bit 0 clear launches nothing.
- R11: Each destination holds its own message. A launch to one destination does not alter another destination's pending data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| tgt_valid | output | 8 | Per-destination message valid (busy) |
| tgt_ready | input | 8 | Per-destination fetch acceptance from the remote core |
| tgt_data | output | 512 | Per-destination 64-bit message, destination i in bits [64i+63:64i] |
| irq | output | 1 | Interrupt, high while the pending bit is set |

## Verification
The hardest case to reach is an overflow. It needs a second launch while a message is still parked, and the bench must then show that the parked data survived. The bench holds `tgt_ready` low and stages a fresh pair of words. It relaunches to the same destination, then reads the stream data and the status word before any fetch. The interrupt paths are driven with one event type masked and the other open. This shows that each mask bit gates only its own event and that the global bit gates both.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned BUSY_LSB = 0;
  localparam int unsigned OVF_LSB  = 8;
  localparam int unsigned DLV_LSB  = 16;
  localparam int unsigned MSK_ALL  = 0;
  localparam int unsigned MSK_OVF  = 1;
  localparam int unsigned MSK_DLV  = 2;
  localparam int unsigned MSK_W    = 3;

  typedef enum logic [2:0] {
    SEL_DEST = 3'd0,
    SEL_LO   = 3'd1,
    SEL_HI   = 3'd2,
    SEL_GO   = 3'd3,
    SEL_CLR  = 3'd4,
    SEL_STS  = 3'd5,
    SEL_PEND = 3'd6,
    SEL_MASK = 3'd7
  } reg_sel_e;

  // word-aligned address inside the 32-byte window
  function automatic logic addr_hit(input logic [7:0] a);
    return (a[7:5] == 3'b000) && (a[1:0] == 2'b00);
  endfunction
endpackage

// File: rtl/mbx_regfile.sv
module mbx_regfile
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_TGT = 8,
  localparam int unsigned ID_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [7:0]         addr,
  input  logic [REG_W-1:0]   wdata,
  output logic [ID_W-1:0]    dest_q,
  output logic [REG_W-1:0]   lo_q,
  output logic [REG_W-1:0]   hi_q,
  output logic [MSK_W-1:0]   mask_q,
  output logic               go,
  output logic [NUM_TGT-1:0] clr_dlv,
  output logic [NUM_TGT-1:0] clr_ovf,
  output logic               pend_clr
);
  reg_sel_e sel;
  logic     wr_ok;

  assign sel   = reg_sel_e'(addr[4:2]);
  assign wr_ok = wr && addr_hit(addr);

  assign go       = wr_ok && (sel == SEL_GO) && wdata[0];
  assign pend_clr = wr_ok && (sel == SEL_PEND) && wdata[0];
  assign clr_dlv  = (wr_ok && sel == SEL_CLR) ? wdata[DLV_LSB +: NUM_TGT] : '0;
  assign clr_ovf  = (wr_ok && sel == SEL_CLR) ? wdata[OVF_LSB +: NUM_TGT] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      mask_q <= '1;
    end else if (wr_ok) begin
      unique case (sel)
        SEL_DEST: dest_q <= wdata[ID_W-1:0];
        SEL_LO:   lo_q   <= wdata;
        SEL_HI:   hi_q   <= wdata;
        SEL_MASK: mask_q <= wdata[MSK_W-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int unsigned MSG_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [MSG_W-1:0] msg,
  input  logic             ready,
  input  logic             clr_dlv,
  input  logic             clr_ovf,
  output logic             valid,
  output logic [MSG_W-1:0] data,
  output logic             dlv,
  output logic             ovf,
  output logic             dlv_ev,
  output logic             ovf_ev
);
  assign dlv_ev = valid && ready;
  assign ovf_ev = launch && valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (dlv_ev) begin
      valid <= 1'b0;
    end else if (launch && !valid) begin
      valid <= 1'b1;
      data  <= msg;
    end
  end

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlv <= 1'b0;
      ovf <= 1'b0;
    end else begin
      if (dlv_ev)       dlv <= 1'b1;
      else if (clr_dlv) dlv <= 1'b0;
      if (ovf_ev)       ovf <= 1'b1;
      else if (clr_ovf) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
  import mbx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MSK_W-1:0] mask,
  input  logic             any_dlv,
  input  logic             any_ovf,
  input  logic             clr,
  output logic             pend
);
  logic set;

  assign set = !mask[MSK_ALL] &&
               ((any_dlv && !mask[MSK_DLV]) || (any_ovf && !mask[MSK_OVF]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend <= 1'b0;
    else if (set) pend <= 1'b1;
    else if (clr) pend <= 1'b0;
  end
endmodule

// File: rtl/mbx_tx_ctrl.sv
module mbx_tx_ctrl
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_TGT = 8,
  localparam int unsigned MSG_W = 2 * REG_W,
  localparam int unsigned ID_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [7:0]               reg_addr,
  input  logic [REG_W-1:0]         reg_wdata,
  output logic [REG_W-1:0]         reg_rdata,
  output logic [NUM_TGT-1:0]       tgt_valid,
  input  logic [NUM_TGT-1:0]       tgt_ready,
  output logic [NUM_TGT*MSG_W-1:0] tgt_data,
  output logic                     irq
);
  logic [ID_W-1:0]    dest_q;
  logic [REG_W-1:0]   lo_q, hi_q;
  logic [MSK_W-1:0]   mask_q;
  logic               go_w, pend_clr_w, pend_q;
  logic [NUM_TGT-1:0] clr_dlv_w, clr_ovf_w, dlv_w, ovf_w, dlv_ev_w, ovf_ev_w;

  mbx_regfile #(.NUM_TGT(NUM_TGT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .dest_q(dest_q), .lo_q(lo_q), .hi_q(hi_q), .mask_q(mask_q), .go(go_w),
    .clr_dlv(clr_dlv_w), .clr_ovf(clr_ovf_w), .pend_clr(pend_clr_w)
  );

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_slot
    mbx_slot #(.MSG_W(MSG_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .launch(go_w && (dest_q == ID_W'(g))),
      .msg({hi_q, lo_q}),
      .ready(tgt_ready[g]),
      .clr_dlv(clr_dlv_w[g]), .clr_ovf(clr_ovf_w[g]),
      .valid(tgt_valid[g]),
      .data(tgt_data[g*MSG_W +: MSG_W]),
      .dlv(dlv_w[g]), .ovf(ovf_w[g]),
      .dlv_ev(dlv_ev_w[g]), .ovf_ev(ovf_ev_w[g])
    );
  end

  mbx_irq u_irq (
    .clk(clk), .rst_n(rst_n), .mask(mask_q),
    .any_dlv(|dlv_ev_w), .any_ovf(|ovf_ev_w),
    .clr(pend_clr_w), .pend(pend_q)
  );

  assign irq = pend_q;

  always_comb begin
    reg_rdata = '0;
    if (addr_hit(reg_addr)) begin
      unique case (reg_sel_e'(reg_addr[4:2]))
        SEL_DEST: reg_rdata[ID_W-1:0] = dest_q;
        SEL_LO:   reg_rdata = lo_q;
        SEL_HI:   reg_rdata = hi_q;
        SEL_STS: begin
          reg_rdata[BUSY_LSB +: NUM_TGT] = tgt_valid;
          reg_rdata[OVF_LSB  +: NUM_TGT] = ovf_w;
          reg_rdata[DLV_LSB  +: NUM_TGT] = dlv_w;
        end
        SEL_PEND: reg_rdata[0] = pend_q;
        SEL_MASK: reg_rdata[MSK_W-1:0] = mask_q;
        default:  reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mbx_tx_ctrl_chk.sv
module mbx_tx_ctrl_chk #(
  parameter int unsigned NUM_TGT = 8,
  parameter int unsigned MSG_W   = 64,
  parameter int unsigned ID_W    = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_TGT-1:0]       tgt_valid,
  input logic [NUM_TGT-1:0]       tgt_ready,
  input logic [NUM_TGT*MSG_W-1:0] tgt_data,
  input logic [NUM_TGT-1:0]       dlv,
  input logic [NUM_TGT-1:0]       ovf,
  input logic [ID_W-1:0]          dest,
  input logic                     go,
  input logic                     pend_clr,
  input logic                     irq
);
  for (genvar g = 0; g < NUM_TGT; g++) begin : g_chk
    p_hold_msg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_valid[g] && !tgt_ready[g] |=>
        tgt_valid[g] && $stable(tgt_data[g*MSG_W +: MSG_W]));

    p_fetch_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_valid[g] && tgt_ready[g] |=> !tgt_valid[g] && dlv[g]);

    p_no_overwrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
      go && (dest == ID_W'(g)) && tgt_valid[g] && !tgt_ready[g] |=>
        ovf[g] && $stable(tgt_data[g*MSG_W +: MSG_W]));
  end

  p_ack_drops_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr && !go && !(|(tgt_valid & tgt_ready)) |=> !irq);
endmodule

bind mbx_tx_ctrl mbx_tx_ctrl_chk #(
  .NUM_TGT(NUM_TGT), .MSG_W(MSG_W), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tgt_valid(tgt_valid), .tgt_ready(tgt_ready),
  .tgt_data(tgt_data), .dlv(dlv_w), .ovf(ovf_w), .dest(dest_q),
  .go(go_w), .pend_clr(pend_clr_w), .irq(irq)
);

// File: tb/test_mbx_tx_ctrl.sv
`timescale 1ns/1ps
module test_mbx_tx_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [7:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [7:0]   tgt_valid;
  logic [7:0]   tgt_ready = '0;
  logic [511:0] tgt_data;
  logic         irq;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  mbx_tx_ctrl i_mbx_tx_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tgt_valid(tgt_valid),
    .tgt_ready(tgt_ready), .tgt_data(tgt_data), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic send(input int t, input logic [31:0] hi, input logic [31:0] lo);
    wr(8'h00, t); wr(8'h04, lo); wr(8'h08, hi); wr(8'h0C, 32'h1);
  endtask

  task automatic fetch(input int t);
    tgt_ready[t] = 1'b1;
    @(posedge clk); @(negedge clk);
    tgt_ready[t] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h1C, v); check("R1 mask", v, 7);
    rd(8'h14, v); check("R1 status", v, 0);
    rd(8'h18, v); check("R1 pending", v, 0);
    check("R1 irq", irq, 0);
    check("R1 valid", tgt_valid, 0);
  endtask

  task automatic t_stage();
    logic [31:0] v;
    wr(8'h00, 32'hD); rd(8'h00, v); check("R2 dest", v, 5);
    wr(8'h04, 32'h1234_5678); rd(8'h04, v); check("R2 lo", v, 32'h1234_5678);
    wr(8'h08, 32'h9ABC_DEF0); rd(8'h08, v); check("R2 hi", v, 32'h9ABC_DEF0);
  endtask

  task automatic t_send();
    logic [31:0] v;
    wr(8'h00, 3); wr(8'h04, 32'hAAAA_0001); wr(8'h08, 32'hBBBB_0002);
    wr(8'h0C, 32'h2);
    check("R10 no launch", tgt_valid, 0);
    wr(8'h0C, 32'h1);
    check("R3 valid", tgt_valid, 8'h08);
    check("R3 data", tgt_data[3*64 +: 64], 64'hBBBB_0002_AAAA_0001);
    rd(8'h14, v); check("R3 busy", v, 32'h0000_0008);
    repeat (3) @(negedge clk);
    check("R3 held", tgt_data[3*64 +: 64], 64'hBBBB_0002_AAAA_0001);
  endtask

  task automatic t_fetch();
    logic [31:0] v;
    fetch(3);
    check("R4 valid low", tgt_valid, 0);
    rd(8'h14, v); check("R4 delivered", v, 32'h0008_0000);
    check("R7 masked irq", irq, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    send(2, 32'h2222_0000, 32'h0000_2222);
    send(6, 32'h6666_0000, 32'h0000_6666);
    check("R11 slot2", tgt_data[2*64 +: 64], 64'h2222_0000_0000_2222);
    send(2, 32'hDEAD_BEEF, 32'hFEED_F00D);
    check("R5 kept", tgt_data[2*64 +: 64], 64'h2222_0000_0000_2222);
    check("R11 slot6", tgt_data[6*64 +: 64], 64'h6666_0000_0000_6666);
    rd(8'h14, v); check("R5 status", v, 32'h0008_0444);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    fetch(2);
    rd(8'h14, v); check("R4 dlv2", v, 32'h000C_0440);
    wr(8'h10, 32'h0004_04FF);
    rd(8'h14, v); check("R6 selective", v, 32'h0008_0040);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(8'h1C, 32'h1);
    fetch(6);
    check("R7 global mask", irq, 0);
    wr(8'h1C, 32'h2);
    send(1, 32'h1, 32'h1);
    wr(8'h0C, 32'h1);
    check("R8 ovf masked", irq, 0);
    fetch(1);
    check("R7 delivery irq", irq, 1);
    rd(8'h18, v); check("R7 pending", v, 1);
    wr(8'h18, 32'h1);
    check("R9 cleared", irq, 0);
    wr(8'h1C, 32'h4);
    send(0, 32'h0, 32'h7);
    check("R8 no irq yet", irq, 0);
    wr(8'h0C, 32'h1);
    check("R8 ovf irq", irq, 1);
    wr(8'h18, 32'h1);
    fetch(0);
    check("R7 dlv masked", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stage();
    t_send();
    t_fetch();
    t_overflow();
    t_clear();
    t_irq();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule